// File: doc/BRIEF.md
# Configurable Order Delta-Sigma Audio Modulator

This block turns signed PCM audio samples into a single-bit pulse stream that can drive an output pin, with an analog low-pass filter after the pin recovering the audio. Each sample is held for a fixed number of modulator steps (the oversampling ratio, about 2000 for 48 kHz audio), while a chain of one, two or three integrators shapes the quantization noise away from the audio band.

The loop order, the feedback weight of each integrator and an optional return-to-zero output mode are all chosen at run time, so different noise-shaping schemes can be compared one after another on the same hardware. The configuration is taken only while the block is held in reset or clear, so a running loop never changes structure mid-stream. Integrators saturate instead of wrapping, so that an overloaded higher-order loop can recover.

Top module: `dsm_audio_mod`

## Requirements
- R1: While `rst` or `clr` is high, all integrators, the held sample, the step counter, the phase and the output bit are cleared; `dout` reads 0 on the cycle after, and `s_ready` is low while either is high.
- R2: `order_sel`, `coef_sel` and `rz_en` are copied into the active configuration only on clock edges where `rst` or `clr` is high; changes at other times have no effect on `dout`.
- R3: `order_sel` value 2 selects a second-order loop, 3 a third-order loop, and 0 or 1 a first-order loop; integrators beyond the selected order stay at zero.
- R4: On every step, with `x` the held sample, `q` the current output bit and `f_k` the feedback of stage k: stage 1 becomes `s1 + x - f_1`, stage 2 becomes `s2 + s1 - f_2`, stage 3 becomes `s3 + s2 - f_3`, all using the values before the step; for a first-order loop with unit weight the long-run density of ones is (1 + x/2^(IN_W-1))/2.
- R5: Stage k's weight is the signed field `coef_sel[k*COEF_W +: COEF_W]` (stage 1 at k=0) with COEF_FRAC fractional bits; `f_k` is weight·2^(IN_W-1) when `q` is 1 and its negation when `q` is 0, so a weight field of 16 (with COEF_FRAC=4) is unit feedback and the second-order loop with both weights at 16 is available.
- R6: The new output bit is 1 when the updated value of the last active integrator is zero or positive, else 0; it appears on `dout` the cycle after the step.
- R7: Every integrator saturates at its signed ACC_W-bit limits instead of wrapping.
- R8: `s_ready` is high for exactly one step in every OSR steps (the last step of a sample period); if `s_valid` is high then, `s_data` becomes the held sample from the next step on, otherwise the previous sample is kept.
- R9: With return-to-zero active, the loop steps only on every second clock; `dout` carries the new bit for one cycle after a step and is 0 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset, also loads configuration |
| clr | input | 1 | Synchronous loop clear, also loads configuration |
| order_sel | input | 2 | Requested loop order (0/1, 2, 3) |
| coef_sel | input | 3*COEF_W | Three signed stage weights, stage 1 in the low field |
| rz_en | input | 1 | Requests return-to-zero output shaping |
| s_valid | input | 1 | PCM sample offered |
| s_data | input | IN_W | Signed PCM sample |
| s_ready | output | 1 | Sample accepted on this cycle if offered |
| dout | output | 1 | Registered single-bit modulator output |

## Verification
The assertions watch, on every cycle, that the active configuration stays still outside reset and clear, that stages beyond the chosen order stay at zero, that return-to-zero off-phases drive the pin low, that `s_ready` never lasts two cycles and the held sample moves only on a handshake, and that a nearly full integrator never jumps to the other sign. The exact bit stream for each order, weight set and output mode, the ones density against the input level, the hold-on-no-valid behaviour and the way saturation delays recovery after overload are shown only by the bench, which runs an independent model of the loop equations against `dout` and `s_ready` cycle by cycle.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int MAX_STAGES = 3;

  // 0 and 1 both mean a first-order loop
  function automatic logic [1:0] norm_order(input logic [1:0] sel);
    return (sel == 2'd0) ? 2'd1 : sel;
  endfunction
endpackage

// File: rtl/dsm_rate_ctrl.sv
module dsm_rate_ctrl #(
  parameter int OSR = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rz,
  output logic step,
  output logic strobe
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt;
  logic          ph;

  assign step   = !rz || !ph;
  assign strobe = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else begin
      ph <= rz ? ~ph : 1'b0;
      if (step) begin
        if (cnt == LAST) cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    active,
  input  logic signed [ACC_W-1:0] din,
  input  logic signed [ACC_W-1:0] fbk,
  output logic signed [ACC_W-1:0] nxt,
  output logic signed [ACC_W-1:0] st
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [SW-1:0] sum;
  logic signed [ACC_W-1:0] clip;

  always_comb begin
    sum = $signed({{2{st[ACC_W-1]}}, st})
        + $signed({{2{din[ACC_W-1]}}, din})
        - $signed({{2{fbk[ACC_W-1]}}, fbk});
    if (sum > MAXV)      clip = MAXV[ACC_W-1:0];
    else if (sum < MINV) clip = MINV[ACC_W-1:0];
    else                 clip = sum[ACC_W-1:0];
    nxt = active ? clip : '0;
  end

  always_ff @(posedge clk) begin
    if (clear)     st <= '0;
    else if (step) st <= nxt;
  end
endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    clear,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] last_nxt,
  output logic                    q,
  output logic                    dout
);
  logic bit_new;
  assign bit_new = !last_nxt[ACC_W-1];

  always_ff @(posedge clk) begin
    if (clear) begin
      q    <= 1'b0;
      dout <= 1'b0;
    end else begin
      if (step) q <= bit_new;
      dout <= step ? bit_new : 1'b0;
    end
  end
endmodule

// File: rtl/dsm_audio_mod.sv
module dsm_audio_mod #(
  parameter int IN_W      = 16,
  parameter int ACC_W     = 24,
  parameter int COEF_W    = 8,
  parameter int COEF_FRAC = 4,
  parameter int OSR       = 2000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic [1:0]            order_sel,
  input  logic [3*COEF_W-1:0]   coef_sel,
  input  logic                  rz_en,
  input  logic                  s_valid,
  input  logic [IN_W-1:0]       s_data,
  output logic                  s_ready,
  output logic                  dout
);
  import dsm_pkg::*;

  localparam int NST = MAX_STAGES;
  localparam int SH  = IN_W - 1 - COEF_FRAC;

  logic                     clear;
  logic [1:0]               ord_act;
  logic [NST*COEF_W-1:0]    coef_act;
  logic                     rz_act;
  logic signed [IN_W-1:0]   x_hold;
  logic                     step, strobe, q;
  logic signed [ACC_W-1:0]  st   [NST];
  logic signed [ACC_W-1:0]  nxt  [NST];
  logic signed [ACC_W-1:0]  din  [NST];
  logic signed [ACC_W-1:0]  fbk  [NST];
  logic signed [ACC_W-1:0]  last_nxt;
  logic signed [ACC_W-1:0]  st1_w, st2_w, st3_w;

  assign clear = rst || clr;

  // configuration is only sampled while the loop is held
  always_ff @(posedge clk) begin
    if (clear) begin
      ord_act  <= norm_order(order_sel);
      coef_act <= coef_sel;
      rz_act   <= rz_en;
    end
  end

  dsm_rate_ctrl #(.OSR(OSR)) u_rate (
    .clk(clk), .rst(rst), .clr(clr), .rz(rz_act),
    .step(step), .strobe(strobe)
  );

  assign s_ready = strobe && !clear;

  always_ff @(posedge clk) begin
    if (clear)                   x_hold <= '0;
    else if (s_ready && s_valid) x_hold <= $signed(s_data);
  end

  genvar k;
  generate
    for (k = 0; k < NST; k++) begin : g_stage
      logic signed [COEF_W-1:0] cw;
      logic signed [ACC_W-1:0]  mag;
      assign cw  = $signed(coef_act[k*COEF_W +: COEF_W]);
      assign mag = $signed({{(ACC_W-COEF_W){cw[COEF_W-1]}}, cw}) <<< SH;
      assign fbk[k] = q ? mag : -mag;

      if (k == 0) begin : g_in
        assign din[k] = $signed({{(ACC_W-IN_W){x_hold[IN_W-1]}}, x_hold});
      end else begin : g_chain
        assign din[k] = st[k-1];
      end

      dsm_integrator #(.ACC_W(ACC_W)) u_int (
        .clk(clk), .clear(clear), .step(step),
        .active(k < int'(ord_act)),
        .din(din[k]), .fbk(fbk[k]),
        .nxt(nxt[k]), .st(st[k])
      );
    end
  endgenerate

  always_comb begin
    case (ord_act)
      2'd2:    last_nxt = nxt[1];
      2'd3:    last_nxt = nxt[2];
      default: last_nxt = nxt[0];
    endcase
  end

  dsm_quantizer #(.ACC_W(ACC_W)) u_quant (
    .clk(clk), .clear(clear), .step(step),
    .last_nxt(last_nxt), .q(q), .dout(dout)
  );

  assign st1_w = st[0];
  assign st2_w = st[1];
  assign st3_w = st[2];
endmodule

// File: rtl/dsm_audio_mod_chk.sv
module dsm_audio_mod_chk #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 24,
  parameter int COEF_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clr,
  input logic                    s_valid,
  input logic                    s_ready,
  input logic                    dout,
  input logic                    step,
  input logic                    rz_act,
  input logic [1:0]              ord_act,
  input logic [3*COEF_W-1:0]     coef_act,
  input logic signed [IN_W-1:0]  x_hold,
  input logic signed [ACC_W-1:0] st1,
  input logic signed [ACC_W-1:0] st2,
  input logic signed [ACC_W-1:0] st3
);
  localparam logic signed [ACC_W-1:0] QTR  = {2'b01, {(ACC_W-2){1'b0}}};
  localparam logic signed [ACC_W-1:0] NQTR = -QTR;

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dout == 1'b0 && st1 == '0 && !s_ready));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ($stable(ord_act) && $stable(coef_act) && $stable(rz_act)));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (ord_act == 2'd1) |-> (st2 == '0 && st3 == '0));

  assert_third_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (ord_act == 2'd2) |-> (st3 == '0));

  assert_no_wrap_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && st1 >= QTR) |=> (st1 > 0));

  assert_no_wrap_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && st1 <= NQTR) |=> (st1 < 0));

  assert_ready_single_R8: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);

  assert_hold_sample_R8: assert property (@(posedge clk) disable iff (rst || clr)
    !(s_ready && s_valid) |=> $stable(x_hold));

  assert_rz_low_R9: assert property (@(posedge clk) disable iff (rst)
    (rz_act && !step && !clr) |=> !dout);
endmodule

bind dsm_audio_mod dsm_audio_mod_chk #(
  .IN_W(IN_W), .ACC_W(ACC_W), .COEF_W(COEF_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .s_valid(s_valid), .s_ready(s_ready),
  .dout(dout), .step(step), .rz_act(rz_act), .ord_act(ord_act),
  .coef_act(coef_act), .x_hold(x_hold),
  .st1(st1_w), .st2(st2_w), .st3(st3_w)
);

// File: tb/dsm_audio_mod_tb.sv
module dsm_audio_mod_tb;
  localparam int IN_W = 16, ACC_W = 24, COEF_W = 8, COEF_FRAC = 4, OSR = 4;
  localparam int SH = IN_W - 1 - COEF_FRAC;
  localparam longint MAXV = (longint'(1) <<< (ACC_W-1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (ACC_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, rz_en = 1'b0, s_valid = 1'b0;
  logic [1:0] order_sel = 2'd1;
  logic [3*COEF_W-1:0] coef_sel = '0;
  logic [IN_W-1:0] s_data = '0;
  logic s_ready, dout;

  always #10 clk = ~clk;

  dsm_audio_mod #(.IN_W(IN_W), .ACC_W(ACC_W), .COEF_W(COEF_W),
                  .COEF_FRAC(COEF_FRAC), .OSR(OSR)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .order_sel(order_sel),
    .coef_sel(coef_sel), .rz_en(rz_en), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .dout(dout)
  );

  int total = 0, bad = 0, mm = 0, ones = 0, rdys = 0;
  bit finished = 1'b0;

  // independent loop model
  longint ms [3];
  longint mc [3];
  longint mx;
  bit mq, md, mph, mrz;
  int mcnt, mord;

  function automatic longint satv(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(bit ok, int req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_ready();
    return !rst && !clr && (!mrz || !mph) && (mcnt == OSR-1);
  endfunction

  task automatic model_edge();
    longint n [3];
    longint f [3];
    bit stp;
    if (rst || clr) begin
      mord = (order_sel == 2'd2) ? 2 : (order_sel == 2'd3) ? 3 : 1;
      for (int k = 0; k < 3; k++)
        mc[k] = longint'($signed(coef_sel[k*COEF_W +: COEF_W]));
      mrz = rz_en;
      for (int k = 0; k < 3; k++) ms[k] = 0;
      mq = 0; md = 0; mph = 0; mcnt = 0; mx = 0;
    end else begin
      stp = !mrz || !mph;
      mph = mrz ? !mph : 1'b0;
      if (stp) begin
        for (int k = 0; k < 3; k++) f[k] = (mq ? 1 : -1) * mc[k] * (longint'(1) <<< SH);
        n[0] = satv(ms[0] + mx - f[0]);
        n[1] = (mord >= 2) ? satv(ms[1] + ms[0] - f[1]) : 0;
        n[2] = (mord == 3) ? satv(ms[2] + ms[1] - f[2]) : 0;
        mq = (n[mord-1] >= 0);
        md = mq;
        if (mcnt == OSR-1) begin
          mcnt = 0;
          if (s_valid) mx = longint'($signed(s_data));
        end else mcnt++;
        for (int k = 0; k < 3; k++) ms[k] = n[k];
      end else md = 0;
    end
  endtask

  // one clock: model the edge, then compare at the falling edge
  task automatic cyc();
    if (s_ready !== model_ready()) mm++;
    if (s_ready && s_valid) rdys++;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    if (dout !== md) mm++;
    if (dout) ones++;
  endtask

  task automatic configure(logic [1:0] o, logic [7:0] c1, logic [7:0] c2, logic [7:0] c3, logic rz);
    order_sel = o; coef_sel = {c3, c2, c1}; rz_en = rz;
    clr = 1'b1; cyc(); clr = 1'b0;
  endtask

  task automatic run(int n);
    mm = 0; ones = 0; rdys = 0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  typedef struct packed {
    logic [1:0]  ord;
    logic [7:0]  c1, c2, c3;
    logic        rz;
    logic [15:0] x;
    logic [15:0] n;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd1, 8'd16, 8'd0,  8'd0,  1'b0, 16'd8192,  16'd200, 4'd4}, // R4 first order
    '{2'd2, 8'd16, 8'd16, 8'd0,  1'b0, 16'hD120,  16'd300, 4'd5}, // R5 unit pair
    '{2'd3, 8'd16, 8'd8,  8'd4,  1'b0, 16'd6000,  16'd300, 4'd4}, // R4 third order
    '{2'd0, 8'd16, 8'd40, 8'd40, 1'b0, 16'd3000,  16'd200, 4'd3}, // R3 zero is first
    '{2'd2, 8'd16, 8'd16, 8'd0,  1'b1, 16'd9000,  16'd300, 4'd9}, // R9 rz
    '{2'd1, 8'd0,  8'd0,  8'd0,  1'b0, 16'h7FFF,  16'd600, 4'd7}, // R7 overload
    '{2'd2, 8'd24, 8'hF8, 8'd0,  1'b0, 16'hF000,  16'd300, 4'd6}, // R6 mixed signs
    '{2'd3, 8'd16, 8'd12, 8'd6,  1'b1, 16'hE000,  16'd300, 4'd3}  // R3 rz third
  };

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; cyc(); cyc();
    check(dout == 1'b0, 1, dout, 0);                 // R1 reset output
    check(s_ready == 1'b0, 1, s_ready, 0);           // R1 no ready in reset
    rst = 1'b0;

    foreach (VECS[i]) begin
      configure(VECS[i].ord, VECS[i].c1, VECS[i].c2, VECS[i].c3, VECS[i].rz);
      s_valid = 1'b1; s_data = VECS[i].x;
      run(int'(VECS[i].n));
      check(mm == 0, int'(VECS[i].req), mm, 0);
    end

    // R7: after long overload, recovery is delayed by a saturated (not wrapped) integrator
    configure(2'd1, 8'd0, 8'd0, 8'd0, 1'b0);
    s_valid = 1'b1; s_data = 16'h7FFF; run(700);
    s_data = 16'h8000; run(60);
    check(ones == 60 && mm == 0, 7, ones, 60);

    // R4: ones density for unit first-order loop at half scale is 0.75
    configure(2'd1, 8'd16, 8'd0, 8'd0, 1'b0);
    s_valid = 1'b1; s_data = 16'd16384; run(8);
    run(400);
    check(ones >= 297 && ones <= 303, 4, ones, 300);

    // R8: one accept every OSR steps, then hold when nothing is offered
    configure(2'd1, 8'd16, 8'd0, 8'd0, 1'b0);
    s_valid = 1'b1; s_data = 16'd10000; run(40);
    check(rdys == 40 / OSR, 8, rdys, 40 / OSR);
    s_valid = 1'b0; s_data = 16'hB1E0; run(80);
    check(mm == 0 && rdys == 0, 8, mm, 0);
    // R8: density still follows the held positive sample
    check(ones > 40, 8, ones, 41);

    // R2: config changes without clear have no effect
    configure(2'd2, 8'd16, 8'd16, 8'd0, 1'b0);
    s_valid = 1'b1; s_data = 16'd5000; run(20);
    order_sel = 2'd3; coef_sel = {8'd50, 8'd90, 8'd70}; rz_en = 1'b1;
    run(100);
    check(mm == 0, 2, mm, 0);

    // R9: in rz mode at most half the cycles are high
    configure(2'd1, 8'd16, 8'd0, 8'd0, 1'b1);
    s_valid = 1'b1; s_data = 16'h7000; run(200);
    check(ones <= 100 && mm == 0, 9, ones, 100);

    // R1: clear in mid-stream zeroes the output and restarts the loop
    s_data = 16'h7FFF; run(30);
    clr = 1'b1; cyc(); clr = 1'b0;
    check(dout == 1'b0, 1, dout, 0);
    run(50);
    check(mm == 0, 1, mm, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule